// File: doc/BRIEF.md
# Frame Capture Sequencer Registers

This block is the software-facing control point of an engine that copies one displayed frame from a pixel source into memory. A 32-bit register bus reaches five word registers. These hold where the frame goes, the row pitch in bytes, the image size, a control/status word and a line progress count. The pointer, pitch and size are handed unchanged to the sibling blocks that pack pixels and generate addresses.

A start command captures exactly one frame. Those sibling blocks report back through two single-cycle pulses: one when a line has been committed to memory and one when the frame is finished. The block keeps a busy flag, gates memory writes with it and counts the committed lines. It can abort a frame part-way through and can request a fresh frame start from the source at end of frame. It raises a level interrupt while it is idle and the interrupt enable is set. Software acknowledges that interrupt by clearing the enable bit.

Top module: `capseq_top`

## Requirements
- R1: After reset the control word at offset 0x0C reads 0x5440_0000. Pointer, pitch, size and progress read 0. `irq`, `wr_allow` and `src_vstart` are low.
- R2: Pointer (0x00), pitch (0x04) and size (0x08) read back what was written. Size bits 15:0 drive `img_width` and bits 31:16 drive `img_height`. Any other word offset reads 0.
- R3: Control bits 31:24 always read 0x54 and bits 23:22 always read 01, whatever is written. Bits 2 (interrupt enable), 3 (odd field, drives `odd_field`), 15 (restart at end of frame) and 21 (power-down, drives `mem_pwrdn`) read back as written. Bit 0 (start) and bit 14 (abort) read 0. Bit 1 reads the busy state. Every other bit reads 0.
- R4: A control write is accepted as a start when it has bit 0 set and bits 14 and 21 clear, and the engine is idle. From the next cycle bit 1 and `wr_allow` read 1, and `src_vstart` is high for exactly one cycle.
- R5: A start written while busy is ignored: there is no `src_vstart` pulse and progress is not reset. A start written with bit 21 set is ignored: the engine stays idle.
- R6: A `frame_done` pulse while busy clears busy and `wr_allow` on the next cycle.
- R7: A control write with bit 14 set while busy clears busy and `wr_allow` on the next cycle. The progress count keeps its value.
- R8: Progress (0x10) is cleared by an accepted start. It increments by one on each `line_done` pulse while busy and saturates at the programmed height. `line_done` while idle has no effect.
- R9: When bit 15 is set, a `frame_done` pulse while busy produces a one-cycle `src_vstart` pulse on the next cycle. When bit 15 is clear, `frame_done` produces no pulse.
- R10: `irq` is the registered value of (interrupt enable AND NOT busy). It rises one cycle after the engine is idle with the enable set. It falls one cycle after the enable is cleared, and it stays low while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 1:0 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| line_done | input | 1 | One-cycle pulse per committed line |
| frame_done | input | 1 | One-cycle pulse at frame end |
| dst_ptr | output | 32 | Destination base address |
| dst_pitch | output | 32 | Row pitch in bytes |
| img_width | output | DIM_W | Programmed width |
| img_height | output | DIM_W | Programmed height |
| odd_field | output | 1 | Odd field request to source |
| mem_pwrdn | output | 1 | Internal memory power-down |
| wr_allow | output | 1 | Memory writes permitted (busy) |
| src_vstart | output | 1 | One-cycle frame-start request to source |
| irq | output | 1 | Level interrupt on idle |

## Verification
The hardest states to reach are those where two events meet inside one frame. The first is a start command arriving while a capture is running, which must leave the progress count and the start pulse untouched. The second is line pulses continuing after the count has reached the height. The bench programs a height of three and starts a frame. It commits two lines, issues a second start at that point, and then sends two more lines, so the overrun pulse lands on a saturated counter. A later frame with restart-at-end and the interrupt enable both set shows the end-of-frame request pulse and the delayed rise of the interrupt together.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

   // word indices (byte offset / 4); software depends on them
   localparam int unsigned WI_PTR   = 0;
   localparam int unsigned WI_PITCH = 1;
   localparam int unsigned WI_DIMS  = 2;
   localparam int unsigned WI_CTRL  = 3;
   localparam int unsigned WI_PROG  = 4;
   localparam int unsigned N_CFG    = 3;

   // control word bit positions
   localparam int unsigned CB_GO    = 0;
   localparam int unsigned CB_BUSY  = 1;
   localparam int unsigned CB_IRQEN = 2;
   localparam int unsigned CB_ODD   = 3;
   localparam int unsigned CB_ABORT = 14;
   localparam int unsigned CB_VEOF  = 15;
   localparam int unsigned CB_PWRDN = 21;

   localparam logic [7:0] ID_TAG = 8'h54;
   localparam logic [1:0] ID_REV = 2'b01;

   typedef struct packed {
      logic irq_en;
      logic odd;
      logic veof;
      logic pwrdn;
   } ctrl_cfg_t;

   typedef struct packed {
      logic      go;
      logic      abort;
      ctrl_cfg_t cfg;
   } ctrl_wr_t;

endpackage

// File: rtl/capseq_cfg.sv
module capseq_cfg
   import capseq_pkg::*;
#(
   parameter int unsigned NWORD  = N_CFG,
   parameter int unsigned WORD_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NWORD-1:0]               wr_stb,
   input  logic [WORD_W-1:0]              wdata,
   output logic [NWORD-1:0][WORD_W-1:0]   words
);

   for (genvar gi = 0; gi < NWORD; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          words[gi] <= '0;
         else if (wr_stb[gi]) words[gi] <= wdata;
      end

      a_r2_word_write : assert property (@(posedge clk) disable iff (!rst_n)
         wr_stb[gi] |=> words[gi] == $past(wdata));
   end

endmodule

// File: rtl/capseq_ctrl.sv
module capseq_ctrl
   import capseq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_wr,
   input  ctrl_wr_t  wfields,
   input  logic      frame_done,
   output ctrl_cfg_t cfg,
   output logic      busy,
   output logic      start_acc,
   output logic      vstart
);

   logic abort_cmd;
   logic busy_d;

   assign abort_cmd = ctrl_wr & wfields.abort;
   assign start_acc = ctrl_wr & wfields.go & ~wfields.abort
                    & ~wfields.cfg.pwrdn & ~busy;

   always_comb begin
      busy_d = busy;
      if (start_acc)                     busy_d = 1'b1;
      else if (abort_cmd || frame_done)  busy_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         busy   <= 1'b0;
         vstart <= 1'b0;
      end else begin
         if (ctrl_wr) cfg <= wfields.cfg;
         busy   <= busy_d;
         vstart <= start_acc | (busy & frame_done & cfg.veof);
      end
   end

   a_r4_start_sets_busy : assert property (@(posedge clk) disable iff (!rst_n)
      start_acc |=> busy && vstart);

   a_r5_rise_needs_start : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ctrl_wr && wfields.go && !wfields.cfg.pwrdn));

   a_r6_done_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_done) |=> !busy);

   a_r7_abort_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort_cmd) |=> !busy);

endmodule

// File: rtl/capseq_progress.sv
module capseq_progress #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             busy,
   input  logic             line_done,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count
);

   logic bump;
   assign bump = busy & line_done & (count < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (bump)  count <= count + 1'b1;
   end

   a_r8_clear_on_start : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);

   a_r8_step : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && line_done && !clear && count < limit) |=> count == $past(count) + 1'b1);

   a_r8_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !clear) |=> $stable(count));

endmodule

// File: rtl/capseq_irq.sv
module capseq_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic busy,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_en & ~busy;
   end

   a_r10_ack_drops : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_en) |=> !irq);

   a_r10_quiet_busy : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !irq);

endmodule

// File: rtl/capseq_top.sv
module capseq_top
   import capseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DIM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              line_done,
   input  logic              frame_done,
   output logic [31:0]       dst_ptr,
   output logic [31:0]       dst_pitch,
   output logic [DIM_W-1:0]  img_width,
   output logic [DIM_W-1:0]  img_height,
   output logic              odd_field,
   output logic              mem_pwrdn,
   output logic              wr_allow,
   output logic              src_vstart,
   output logic              irq
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("capseq_top: ADDR_W must reach offset 0x10");
   end
   if (DIM_W < 1 || DIM_W > 16) begin : g_bad_dim
      $error("capseq_top: DIM_W must be 1..16");
   end

   logic [IDX_W-1:0]        widx;
   logic                    wr_any;
   logic [N_CFG-1:0]        cfg_stb;
   logic [N_CFG-1:0][31:0]  cfg_words;
   logic                    ctrl_wr;
   ctrl_wr_t                wfields;
   ctrl_cfg_t               cfg;
   logic                    busy;
   logic                    start_acc;
   logic [DIM_W-1:0]        progress;
   logic [31:0]             ctrl_rd;
   logic                    unused_bits;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign wr_any = bus_sel & bus_wr;

   for (genvar gi = 0; gi < N_CFG; gi++) begin : g_stb
      assign cfg_stb[gi] = wr_any && (widx == IDX_W'(gi));
   end
   assign ctrl_wr = wr_any && (widx == IDX_W'(WI_CTRL));

   assign wfields.go         = bus_wdata[CB_GO];
   assign wfields.abort      = bus_wdata[CB_ABORT];
   assign wfields.cfg.irq_en = bus_wdata[CB_IRQEN];
   assign wfields.cfg.odd    = bus_wdata[CB_ODD];
   assign wfields.cfg.veof   = bus_wdata[CB_VEOF];
   assign wfields.cfg.pwrdn  = bus_wdata[CB_PWRDN];

   capseq_cfg #(.NWORD(N_CFG), .WORD_W(32)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (cfg_stb),
      .wdata  (bus_wdata),
      .words  (cfg_words)
   );

   capseq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .wfields    (wfields),
      .frame_done (frame_done),
      .cfg        (cfg),
      .busy       (busy),
      .start_acc  (start_acc),
      .vstart     (src_vstart)
   );

   capseq_progress #(.CNT_W(DIM_W)) u_prog (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_acc),
      .busy      (busy),
      .line_done (line_done),
      .limit     (img_height),
      .count     (progress)
   );

   capseq_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_en (cfg.irq_en),
      .busy   (busy),
      .irq    (irq)
   );

   assign dst_ptr    = cfg_words[WI_PTR];
   assign dst_pitch  = cfg_words[WI_PITCH];
   assign img_width  = cfg_words[WI_DIMS][DIM_W-1:0];
   assign img_height = cfg_words[WI_DIMS][16 +: DIM_W];
   assign odd_field  = cfg.odd;
   assign mem_pwrdn  = cfg.pwrdn;
   assign wr_allow   = busy;
   assign unused_bits = ^{bus_addr[1:0]};

   always_comb begin
      ctrl_rd            = '0;
      ctrl_rd[31:24]     = ID_TAG;
      ctrl_rd[23:22]     = ID_REV;
      ctrl_rd[CB_PWRDN]  = cfg.pwrdn;
      ctrl_rd[CB_VEOF]   = cfg.veof;
      ctrl_rd[CB_ODD]    = cfg.odd;
      ctrl_rd[CB_IRQEN]  = cfg.irq_en;
      ctrl_rd[CB_BUSY]   = busy;
   end

   always_comb begin
      bus_rdata = '0;
      if      (widx == IDX_W'(WI_PTR))   bus_rdata = cfg_words[WI_PTR];
      else if (widx == IDX_W'(WI_PITCH)) bus_rdata = cfg_words[WI_PITCH];
      else if (widx == IDX_W'(WI_DIMS))  bus_rdata = cfg_words[WI_DIMS];
      else if (widx == IDX_W'(WI_CTRL))  bus_rdata = ctrl_rd;
      else if (widx == IDX_W'(WI_PROG))  bus_rdata = 32'(progress);
   end

   a_r9_eof_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_done && cfg.veof) |=> src_vstart);

   a_r8_never_above_height : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && line_done && progress >= img_height) |=> $stable(progress));

endmodule

// File: tb/test_capseq_top.sv
module test_capseq_top;

   localparam int unsigned CLK_P   = 10;
   localparam int unsigned WD_CYC  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        line_done = 1'b0;
   logic        frame_done = 1'b0;
   logic [31:0] dst_ptr, dst_pitch;
   logic [15:0] img_width, img_height;
   logic        odd_field, mem_pwrdn, wr_allow, src_vstart, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   capseq_top i_capseq_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_done(line_done), .frame_done(frame_done),
      .dst_ptr(dst_ptr), .dst_pitch(dst_pitch),
      .img_width(img_width), .img_height(img_height),
      .odd_field(odd_field), .mem_pwrdn(mem_pwrdn),
      .wr_allow(wr_allow), .src_vstart(src_vstart), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse_line();
      @(negedge clk); line_done = 1'b1;
      @(negedge clk); line_done = 1'b0;
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(5'h0C, v); chk("R1 ctrl reset", v, 32'h5440_0000);
      rd(5'h00, v); chk("R1 ptr reset", v, 32'h0);
      rd(5'h10, v); chk("R1 progress reset", v, 32'h0);
      chk("R1 outputs reset", {29'h0, irq, wr_allow, src_vstart}, 32'h0);
   endtask

   task automatic t_cfg_regs();
      logic [31:0] v;
      wr(5'h00, 32'hDEAD_BEEC);
      wr(5'h04, 32'h0000_1A40);
      wr(5'h08, 32'h0003_0280);
      rd(5'h00, v); chk("R2 ptr readback", v, 32'hDEAD_BEEC);
      rd(5'h04, v); chk("R2 pitch readback", v, 32'h0000_1A40);
      rd(5'h08, v); chk("R2 dims readback", v, 32'h0003_0280);
      chk("R2 width/height out", {img_height, img_width}, 32'h0003_0280);
      chk("R2 ptr out", dst_ptr, 32'hDEAD_BEEC);
      rd(5'h14, v); chk("R2 unmapped read", v, 32'h0);
   endtask

   task automatic t_ctrl_fields();
      logic [31:0] v;
      wr(5'h0C, 32'hFFFF_FFFC);
      rd(5'h0C, v); chk("R3 ctrl fields", v, 32'h5460_800C);
      chk("R3 odd/pwrdn out", {30'h0, odd_field, mem_pwrdn}, 32'h3);
      chk("R7 abort idle no busy", {31'h0, wr_allow}, 32'h0);
      idle_cycle();
      chk("R10 irq rises when idle+en", {31'h0, irq}, 32'h1);
      wr(5'h0C, 32'h0000_0000);
      rd(5'h0C, v); chk("R3 ctrl cleared keeps id", v, 32'h5440_0000);
      chk("R10 irq one cycle after ack", {31'h0, irq}, 32'h1);
      idle_cycle();
      chk("R10 irq low after ack", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_start_pwrdn();
      logic [31:0] v;
      wr(5'h0C, 32'h0020_0001);
      chk("R5 start with pwrdn no pulse", {31'h0, src_vstart}, 32'h0);
      rd(5'h0C, v); chk("R5 start with pwrdn stays idle", v, 32'h5460_0000);
      wr(5'h0C, 32'h0000_0000);
   endtask

   task automatic t_frame();
      logic [31:0] v;
      wr(5'h0C, 32'h0000_0001);
      chk("R4 vstart pulse", {30'h0, src_vstart, wr_allow}, 32'h3);
      rd(5'h0C, v); chk("R4 busy bit, go reads 0", v, 32'h5440_0002);
      idle_cycle();
      chk("R4 vstart one cycle", {31'h0, src_vstart}, 32'h0);
      pulse_line(); pulse_line();
      rd(5'h10, v); chk("R8 two lines", v, 32'h2);
      wr(5'h0C, 32'h0000_0001);
      chk("R5 start while busy no pulse", {31'h0, src_vstart}, 32'h0);
      rd(5'h10, v); chk("R5 progress kept", v, 32'h2);
      pulse_line(); pulse_line();
      rd(5'h10, v); chk("R8 saturate at height", v, 32'h3);
      pulse_frame();
      chk("R6 frame_done clears busy", {31'h0, wr_allow}, 32'h0);
      chk("R9 no restart when bit15 clear", {31'h0, src_vstart}, 32'h0);
      pulse_line();
      rd(5'h10, v); chk("R8 idle line ignored", v, 32'h3);
   endtask

   task automatic t_restart_irq();
      logic [31:0] v;
      wr(5'h0C, 32'h0000_8005);
      rd(5'h10, v); chk("R8 start clears progress", v, 32'h0);
      idle_cycle();
      chk("R10 irq low while busy", {31'h0, irq}, 32'h0);
      pulse_frame();
      chk("R9 restart pulse at eof", {30'h0, src_vstart, wr_allow}, 32'h2);
      idle_cycle();
      chk("R10 irq after frame end", {31'h0, irq}, 32'h1);
      wr(5'h0C, 32'h0000_0000);
      idle_cycle();
      chk("R10 irq acked", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      wr(5'h0C, 32'h0000_0001);
      pulse_line();
      wr(5'h0C, 32'h0000_4000);
      chk("R7 abort clears busy", {31'h0, wr_allow}, 32'h0);
      rd(5'h0C, v); chk("R7 abort reads 0", v, 32'h5440_0000);
      rd(5'h10, v); chk("R7 progress held", v, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_regs();
      t_ctrl_fields();
      t_start_pwrdn();
      t_frame();
      t_restart_irq();
      t_abort();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule